// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial peripheral interface master that a processor drives through a small bank of 32-bit registers. Software chooses the clock polarity, sampling phase, bit order and word length in a configuration register. It also sets a two-stage clock divider there. The block shifts one word each time software writes the transmit register. When the word is done, the block latches the incoming bits into a receive register and raises a "receive ready" event. That event, or the idle-transmitter event, can drive an interrupt line when the matching mask bit is set.

Word lengths run from 4 to 16 bits, plus 32 bits. An optional high-alignment mode is provided for software that keeps short words in the upper half of a 32-bit register. In that mode the data of short words sits at fixed upper bit positions in both data registers. Chip selects are not generated here; the surrounding logic provides them.

Register word addresses: 0 = configuration, 1 = events, 2 = interrupt mask, 3 = transmit (write), 4 = receive (read). Reads of any other address return zero.

Top module: `spi_host_ctl`

## Requirements
- R1: After reset, the configuration register reads 0x2E7F0000: clock idle high, divide-by-16 on, MSB first, master, length field 7, prescale 15, unit disabled. The event register reads 0x100, the mask reads 0, irq is low and sclk is high.
- R2: Configuration bits 23:20 give the word length N as field+1, with field value 0 meaning 32 bits; legal lengths are 4 to 16 and 32. Each accepted transmit write shifts exactly N bits out on mosi and N bits in from miso.
- R3: With the unit idle, sclk sits at the level of configuration bit 29. A word keeps the transmitter busy for exactly N × 4 × (P+1) × D system clock cycles, counted from the write edge. P is bits 19:16, and D is 16 when bit 27 is set and 1 otherwise.
- R4: With bit 28 clear, mosi holds each bit before the leading sclk edge, both sides sample on the leading edge, and data changes on the trailing edge. With bit 28 set, data changes on the leading edge and is sampled on the trailing edge.
- R5: Bit 26 set sends and receives the most significant bit first. Bit 26 clear sends and receives the least significant bit first.
- R6: A write to address 3 starts a word only when enable (bit 24) and master (bit 25) are both set and no word is in progress. Any other write to address 3 is ignored and changes neither the timing nor the data of the word in progress.
- R7: When a word completes, the received bits are placed right-aligned in the receive register and event bit 9 is set. Event bit 8 reads 0 while a word is shifting and 1 otherwise.
- R8: Writing 1 to event bit 9 clears it. Writing 0 leaves it unchanged.
- R9: irq is high exactly when (event bit 9 and mask bit 9) or (event bit 8 and mask bit 8) holds.
- R10: With configuration bit 14 set, words of 8 bits or fewer take transmit data from bits 31:24 and return receive data in bits 23:16. Words of 9 to 16 bits use bits 31:16 in both directions. Longer words stay right-aligned.
- R11: Writing the configuration register with bit 24 clear aborts a word in progress. Bit 8 returns to 1 on the next cycle, sclk returns to its idle level, and no receive event is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for addr (combinational) |
| irq | output | 1 | Masked event interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench places a reference slave on the serial pins and runs many transfers. It varies polarity, phase, bit order, length and alignment for each one.

- The 32-bit length encoding is targeted directly. A design that treats field 0 as zero bits ends the word at once. One that treats it as one bit returns a truncated value.
- The slowest divider setting is timed cycle by cycle. A wrong divider term gives a busy time off by a factor.
- Writes arriving during a transfer are aimed at designs that restart or corrupt the running word. A restart or corruption would show up as a longer busy time or different data at the slave.
- The abort path is checked for a missing return to idle and for a spurious receive event.
- In high-alignment mode, an off-by-one window or a wrong shift shows up as shifted or truncated words at both ends.

// File: rtl/spi_host_ctl.sv
module spi_host_ctl #(
  parameter logic [31:0] MODE_RST = 32'h2E7F_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam logic [2:0]  A_MODE = 3'd0, A_EVT = 3'd1, A_MASK = 3'd2, A_TX = 3'd3, A_RX = 3'd4;
  localparam logic [31:0] MODE_WMASK = 32'h3FFF_4000;

  logic [31:0] mode_q, rx_q, tx_sh, rx_sh;
  logic [1:0]  mask_q;
  logic        ne_q, busy, act;
  logic [5:0]  ecnt;
  logic [8:0]  div;

  wire cpol = mode_q[29];
  wire cpha = mode_q[28];
  wire d16  = mode_q[27];
  wire msbf = mode_q[26];
  wire mstr = mode_q[25];
  wire en   = mode_q[24];
  wire alt  = mode_q[14];
  wire [3:0] lenf = mode_q[23:20];
  wire [3:0] pm   = mode_q[19:16];

  wire [5:0]  nbits   = (lenf == 4'd0) ? 6'd32 : {2'b0, lenf} + 6'd1;
  wire [4:0]  topb    = 5'(nbits - 6'd1);
  wire [8:0]  hlast   = d16 ? {pm, 5'b11111} : {4'b0, pm, 1'b1};
  wire [31:0] lenmask = ~(32'hFFFF_FFFE << topb);
  wire        short8  = nbits <= 6'd8;
  wire        short16 = nbits <= 6'd16;
  wire [6:0]  elast   = {nbits, 1'b0} - 7'd1;

  wire [31:0] tx_word = (alt && short16) ? (wdata >> (short8 ? 5'd24 : 5'd16)) : wdata;

  wire        edge_now = busy && (div == 9'd0);
  wire        samp     = (ecnt[0] == cpha);
  wire        last     = ({1'b0, ecnt} == elast);
  wire [31:0] rx_nx    = msbf ? {rx_sh[30:0], miso} : {miso, rx_sh[31:1]};
  wire [31:0] rx_fin   = samp ? rx_nx : rx_sh;
  wire [31:0] rx_al    = (msbf ? rx_fin : (rx_fin >> (6'd32 - nbits))) & lenmask;
  wire [31:0] rx_word  = (alt && short16) ? (rx_al << 16) : rx_al;

  wire mode_wr = wr_en && (addr == A_MODE);
  wire start   = wr_en && (addr == A_TX) && en && mstr && !busy;

  assign sclk = cpol ^ act;
  assign mosi = msbf ? tx_sh[topb] : tx_sh[0];
  assign irq  = |({ne_q, ~busy} & mask_q);

  always_comb begin
    case (addr)
      A_MODE:  rdata = mode_q;
      A_EVT:   rdata = {22'b0, ne_q, ~busy, 8'b0};
      A_MASK:  rdata = {22'b0, mask_q, 8'b0};
      A_RX:    rdata = rx_q;
      default: rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      mask_q <= 2'b0;
      ne_q   <= 1'b0;
      rx_q   <= 32'b0;
      busy   <= 1'b0;
      act    <= 1'b0;
      ecnt   <= 6'd0;
      div    <= 9'd0;
      tx_sh  <= 32'b0;
      rx_sh  <= 32'b0;
    end else begin
      if (mode_wr) mode_q <= wdata & MODE_WMASK;
      if (wr_en && addr == A_MASK) mask_q <= wdata[9:8];
      if (wr_en && addr == A_EVT && wdata[9]) ne_q <= 1'b0;
      if (mode_wr && !wdata[24]) begin
        busy  <= 1'b0;
        act   <= 1'b0;
        ecnt  <= 6'd0;
        div   <= 9'd0;
        tx_sh <= 32'b0;
        rx_sh <= 32'b0;
      end else if (start) begin
        busy  <= 1'b1;
        act   <= 1'b0;
        ecnt  <= 6'd0;
        div   <= hlast;
        tx_sh <= tx_word;
        rx_sh <= 32'b0;
      end else if (edge_now) begin
        act <= ~act;
        div <= hlast;
        if (samp) rx_sh <= rx_nx;
        else if (ecnt != 6'd0) tx_sh <= msbf ? (tx_sh << 1) : (tx_sh >> 1);
        if (last) begin
          busy <= 1'b0;
          ecnt <= 6'd0;
          rx_q <= rx_word;
          ne_q <= 1'b1;
        end else begin
          ecnt <= ecnt + 6'd1;
        end
      end else if (busy) begin
        div <= div - 9'd1;
      end
    end
  end
endmodule

module spi_host_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [31:0] wdata,
  input logic        busy,
  input logic        en,
  input logic        cpol,
  input logic        sclk,
  input logic [8:0]  div,
  input logic [5:0]  ecnt,
  input logic [5:0]  nbits,
  input logic        ne_q
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sclk == cpol); // R3
  AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && div != 9'd0 && !wr_en) |=> $stable(sclk)); // R3
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> ({1'b0, ecnt} < {nbits, 1'b0})); // R2
  AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !busy); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == 3'd0 && !wdata[24]) |=> !busy); // R11
  AST_NE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(ne_q) |-> $past(busy)); // R7
endmodule

bind spi_host_ctl spi_host_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .busy(busy), .en(en), .cpol(cpol), .sclk(sclk), .div(div), .ecnt(ecnt),
  .nbits(nbits), .ne_q(ne_q)
);

// File: tb/spi_host_ctl_test.sv
`timescale 1ns/1ps
module spi_host_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, miso = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wdata = 32'b0;
  logic [31:0] rdata;
  logic irq, sclk, mosi;
  int checks = 0, errors = 0;

  spi_host_ctl uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
                    .rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso));

  always #2.5 clk = ~clk;

  bit s_arm = 0;
  logic s_cpol, s_cpha, s_msb;
  int s_n, s_ri, s_ti;
  logic [31:0] s_out, s_in;

  function automatic int bpos(int k, int n, logic m);
    return m ? n - 1 - k : k;
  endfunction

  always @(sclk) if (s_arm) begin
    #1;
    if ((sclk != s_cpol) ^ s_cpha) begin
      if (s_ri < s_n) begin s_in[bpos(s_ri, s_n, s_msb)] = mosi; s_ri++; end
    end else begin
      if (s_ti < s_n) miso = s_out[bpos(s_ti, s_n, s_msb)];
      s_ti++;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] a, logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [31:0] lmask(int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  task automatic xfer(logic cp, logic ph, logic d16, logic msb, logic alt, logic [3:0] lf,
                      logic [3:0] pm, logic [31:0] data, logic [31:0] sdata, int dup_at, int abort_at);
    int n, cyc, h;
    logic [31:0] cfg, etx, erx;
    string tg;
    n = (lf == 0) ? 32 : lf + 1;
    h = 2 * (pm + 1) * (d16 ? 16 : 1);
    cfg = (32'(cp) << 29) | (32'(ph) << 28) | (32'(d16) << 27) | (32'(msb) << 26) |
          (32'h3 << 24) | (32'(lf) << 20) | (32'(pm) << 16) | (32'(alt) << 14);
    wr(3'd0, 32'h0);
    wr(3'd0, cfg);
    s_cpol = cp; s_cpha = ph; s_msb = msb; s_n = n; s_out = sdata; s_in = 0; s_ri = 0;
    s_ti = ph ? 0 : 1;
    miso = ph ? 1'b0 : sdata[bpos(0, n, msb)];
    s_arm = 1;
    wr(3'd3, data);
    addr = 3'd1; #1;
    cyc = 0;
    while (!rdata[8] && cyc < 70000) begin
      cyc++;
      if (cyc == dup_at) begin addr = 3'd3; wdata = ~data; wr_en = 1'b1; end
      if (cyc == abort_at) begin addr = 3'd0; wdata = cfg & ~32'h0100_0000; wr_en = 1'b1; end
      @(negedge clk); wr_en = 1'b0; addr = 3'd1; #1;
    end
    #5; s_arm = 0;
    if (abort_at > 0) begin
      chk(cyc == abort_at, "R11 busy after abort", cyc, abort_at);
      chk(rdata[9] == 1'b0, "R11 no receive event", rdata, 32'h100);
      chk(sclk == cp, "R11 sclk idle", sclk, cp);
      return;
    end
    etx = (alt && n <= 8) ? data >> 24 : (alt && n <= 16) ? data >> 16 : data;
    etx &= lmask(n);
    erx = (sdata & lmask(n)) << ((alt && n <= 16) ? 16 : 0);
    chk(cyc == 2 * n * h, dup_at > 0 ? "R6 busy cycles" : "R3 busy cycles", cyc, 2 * n * h);
    tg = alt ? "R10 slave got" : "R2/R4/R5 slave got";
    chk(s_in == etx, tg, s_in, etx);
    chk(s_ri == n, "R2 bits sampled", s_ri, n);
    addr = 3'd4; #1;
    chk(rdata == erx, alt ? "R10 receive reg" : "R7 receive reg", rdata, erx);
    addr = 3'd1; #1;
    chk(rdata[9], "R7 receive event", rdata, 32'h300);
    chk(sclk == cp, "R3 sclk idle", sclk, cp);
    wr(3'd1, 32'h200);
  endtask

  initial begin
    #(5.0 * 190000);
    checks++; errors++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #12 rst_n = 1'b1;
    @(negedge clk);
    addr = 3'd0; #1; chk(rdata == 32'h2E7F_0000, "R1 mode reset", rdata, 32'h2E7F_0000);
    addr = 3'd1; #1; chk(rdata == 32'h100, "R1 event reset", rdata, 32'h100);
    addr = 3'd2; #1; chk(rdata == 32'h0, "R1 mask reset", rdata, 0);
    chk(irq == 1'b0 && sclk == 1'b1, "R1 irq/sclk", {irq, sclk}, 2'b01);

    xfer(0, 0, 0, 1, 0, 4'd7, 4'd0, 32'hA5, 32'h3C, 0, 0);
    xfer(1, 1, 0, 0, 0, 4'd0, 4'd1, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0);
    xfer(0, 1, 1, 1, 0, 4'd3, 4'd15, 32'h9, 32'h6, 0, 0);
    xfer(0, 0, 0, 1, 1, 4'd7, 4'd0, 32'hC300_0000, 32'h81, 0, 0);
    xfer(1, 0, 0, 0, 1, 4'd11, 4'd0, 32'hABC0_0000, 32'hF0F, 0, 0);
    xfer(0, 0, 0, 1, 0, 4'd15, 4'd2, 32'h1234, 32'hBEEF, 40, 0);
    xfer(1, 0, 0, 1, 0, 4'd15, 4'd2, 32'h1234, 32'hBEEF, 0, 30);
    xfer(0, 1, 0, 0, 0, 4'd5, 4'd0, 32'h2A, 32'h15, 0, 0);

    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h0270_0000);
    wr(3'd3, 32'hFF);
    addr = 3'd1; #1;
    chk(rdata == 32'h100, "R6 write ignored when disabled", rdata, 32'h100);
    wr(3'd0, 32'h0170_0000);
    wr(3'd3, 32'hFF);
    addr = 3'd1; #1;
    chk(rdata == 32'h100, "R6 write ignored when not master", rdata, 32'h100);

    wr(3'd2, 32'h100); #1;
    chk(irq == 1'b1, "R9 idle event unmasked", irq, 1);
    wr(3'd2, 32'h200); #1;
    chk(irq == 1'b0, "R9 receive event clear", irq, 0);
    xfer(0, 0, 0, 1, 0, 4'd7, 4'd0, 32'h11, 32'h22, 0, 0);
    wr(3'd2, 32'h200);
    wr(3'd0, 32'h0070_0000 | 32'h0700_0000);
    wr(3'd3, 32'h5A); s_arm = 0;
    addr = 3'd1; #1;
    while (!rdata[8]) begin @(negedge clk); #1; end
    chk(irq == 1'b1, "R9 receive event unmasked", irq, 1);
    wr(3'd1, 32'h0); addr = 3'd1; #1;
    chk(rdata[9] == 1'b1, "R8 zero write keeps event", rdata, 32'h300);
    wr(3'd1, 32'h200); addr = 3'd1; #1;
    chk(rdata[9] == 1'b0 && irq == 1'b0, "R8 one write clears event", rdata, 32'h100);
    wr(3'd2, 32'h0);

    for (int i = 0; i < 30; i++) begin
      int r;
      logic [3:0] lf;
      r = $urandom_range(0, 13);
      lf = (r == 0) ? 4'd0 : 4'(r + 2);
      xfer(1'($urandom), 1'($urandom), 1'b0, 1'($urandom), 1'($urandom), lf,
           4'($urandom_range(0, 3)), $urandom, $urandom, 0, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule